// File: doc/BRIEF.md
# Parallel ADC Readout Sequencer

This block runs a multi-channel, simultaneous-sampling ADC that has one shared parallel bus. After reset it writes a channel-select word to the converter once. On each start request it pulses the convert line and waits for the converter's end-of-all-conversions flag to fall. It then reads the results one by one with a train of read strobes. Each strobe advances the converter's internal result pointer, and the block forwards every 12-bit result, tagged with its channel number, on a valid/ready stream.

Start requests come from a `start_frame` pulse or from an internal sample-period timer. A request that arrives while a frame is still in progress is dropped and sets a sticky overrun flag. The widths of the strobes and the bus turnaround time are parameters counted in clock cycles. The block drives the data bus only while it writes the configuration.

Top module: `adc_frame_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, before any start, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high, `adc_convst` is low, and `m_valid` and `overrun` are low.
- R2: After each reset exactly one configuration write is made, before any convert pulse. `adc_cs_n` is low during the whole `adc_wr_n` low pulse and at its rising edge. At that edge the bus carries the channel mask on bits 7:0 (bit i selects channel i) and zeros on bits 11:8.
- R3: A `cfg_mask` of zero, sampled in the first cycle after reset, is replaced by the default mask 0x1F, which selects channels 0 to 4.
- R4: A start request in idle produces one `adc_convst` high pulse. No read strobe falls until `adc_eoc_n` has fallen after that pulse, and `adc_convst` is never high while `adc_cs_n` or `adc_rd_n` is low.
- R5: Each frame issues exactly popcount(mask) read pulses, from 1 to 8, with `adc_cs_n` low during each of them.
- R6: Each result is output as `m_data` = {channel index in bits 14:12, bus value in bits 11:0}. Within a frame the channels come in ascending order over the set bits of the mask, and the bus value is the one present at the end of the read strobe low time.
- R7: While `m_valid` is high and `m_ready` is low, in the next cycle `adc_rd_n` is high, `m_valid` stays high and `m_data` is unchanged.
- R8: With `timer_en` high, a start request is raised every `timer_period` cycles (a value of 0 counts as 1). Consecutive convert pulses are then exactly `timer_period` cycles apart when each frame finishes within the period.
- R9: A start request from either source while the block is not idle starts no extra frame and sets `overrun`, which stays high until reset.
- R10: `adc_rd_n` and `adc_wr_n` are never low together. Each read strobe is low for exactly RD_LO_W cycles and each write strobe for exactly WR_LO_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_frame | input | 1 | One-cycle request to start a conversion frame |
| timer_en | input | 1 | Enables the periodic start timer |
| timer_period | input | PER_W | Timer period in cycles |
| cfg_mask | input | NCH | Channel mask used for the configuration write |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Configuration write strobe, active low |
| adc_rd_n | output | 1 | Result read strobe, active low |
| adc_convst | output | 1 | Convert start; conversion begins on its rising edge |
| adc_eoc_n | input | 1 | End of all conversions, falls when results are ready |
| adc_data | inout | DW | Shared bidirectional data bus |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | CW+DW | {channel, result} |
| overrun | output | 1 | Sticky start-while-busy flag |

## Verification
The bench sweeps all 256 mask values, which covers non-contiguous masks, single-channel masks and the zero mask that falls back to the default. A behavioural converter model with a wrapping result pointer detects a wrong pulse count: one extra or one missing read makes the pointer drift, so the next frame arrives with shifted channel data, and a direct per-frame strobe count also catches it. Consumers with steady, pseudo-random and long-withheld ready show a design that strobes while the output is full, because that design loses or overwrites samples. The bench also fires a start during a conversion and runs the timer with a period shorter than a frame. A design that queued these requests would show an extra convert pulse, and one that cleared the flag would drop `overrun`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [3:0] {
    ST_BOOT, ST_CFG_LO, ST_CFG_HI, ST_IDLE, ST_CNV,
    ST_WAIT, ST_TURN, ST_RD_LO, ST_RD_HI
  } seq_state_t;

  function automatic int seq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_fall_detect.sv
module adc_seq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/adc_seq_period_timer.sv
module adc_seq_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;
  logic             hit;

  assign hit  = ({1'b0, cnt} + (PER_W+1)'(1)) >= {1'b0, period};
  assign tick = en & hit;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (hit)   cnt <= '0;
    else            cnt <= cnt + PER_W'(1);
  end
endmodule

// File: rtl/adc_seq_chan_pick.sv
module adc_seq_chan_pick #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic [NCH-1:0] pending,
  output logic [CW-1:0]  chan,
  output logic [NCH-1:0] onehot
);
  always_comb begin
    chan   = '0;
    onehot = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        chan      = CW'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int DW           = 12,
  parameter int WR_LO_W      = 2,
  parameter int RD_LO_W      = 2,
  parameter int RD_HI_W      = 2,
  parameter int TURN_W       = 2,
  parameter int CNV_W        = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int PER_W        = 16,
  parameter bit USE_TIMER    = 1'b1,
  parameter logic [NCH-1:0] DEFAULT_MASK = NCH'(31),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_frame,
  input  logic             timer_en,
  input  logic [PER_W-1:0] timer_period,
  input  logic [NCH-1:0]   cfg_mask,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic             adc_convst,
  input  logic             adc_eoc_n,
  inout  wire  [DW-1:0]    adc_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [CW+DW-1:0] m_data,
  output logic             overrun
);
  localparam int TMAX  = seq_max(seq_max(seq_max(WR_LO_W, RD_LO_W),
                                         seq_max(RD_HI_W, TURN_W)), CNV_W);
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_t       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             tdone;
  logic [NCH-1:0]   mask_q, rem_q, pick_onehot;
  logic [CW-1:0]    pick_ch;
  logic             drive_q, fall_seen_q, eoc_fall, tick, start_req, slot_free;

  // bus is driven only during the configuration write
  assign adc_data = drive_q ? {{(DW-NCH){1'b0}}, mask_q} : {DW{1'bz}};

  adc_seq_fall_detect #(.STAGES(SYNC_STAGES)) u_eoc (
    .clk(clk), .rst(rst), .din(adc_eoc_n), .fall(eoc_fall)
  );

  adc_seq_chan_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .pending(rem_q), .chan(pick_ch), .onehot(pick_onehot)
  );

  generate
    if (USE_TIMER) begin : g_tmr
      adc_seq_period_timer #(.PER_W(PER_W)) u_tmr (
        .clk(clk), .rst(rst), .en(timer_en), .period(timer_period), .tick(tick)
      );
    end else begin : g_no_tmr
      assign tick = 1'b0;
    end
  endgenerate

  assign start_req = start_frame | tick;
  assign slot_free = !m_valid || m_ready;

  always_comb begin
    unique case (state)
      ST_CFG_LO: tdone = (cnt == CNT_W'(WR_LO_W - 1));
      ST_CFG_HI: tdone = (cnt == CNT_W'(TURN_W - 1));
      ST_CNV:    tdone = (cnt == CNT_W'(CNV_W - 1));
      ST_TURN:   tdone = (cnt == CNT_W'(TURN_W - 1));
      ST_RD_LO:  tdone = (cnt == CNT_W'(RD_LO_W - 1));
      ST_RD_HI:  tdone = (cnt == CNT_W'(RD_HI_W - 1));
      default:   tdone = 1'b1;
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT:   nxt = ST_CFG_LO;
      ST_CFG_LO: if (tdone) nxt = ST_CFG_HI;
      ST_CFG_HI: if (tdone) nxt = ST_IDLE;
      ST_IDLE:   if (start_req) nxt = ST_CNV;
      ST_CNV:    if (tdone) nxt = ST_WAIT;
      ST_WAIT:   if (fall_seen_q || eoc_fall) nxt = ST_TURN;
      ST_TURN:   if (tdone && slot_free) nxt = ST_RD_LO;
      ST_RD_LO:  if (tdone) nxt = ST_RD_HI;
      ST_RD_HI:  if (tdone) begin
                   if (rem_q == '0)    nxt = ST_IDLE;
                   else if (slot_free) nxt = ST_RD_LO;
                 end
      default:   nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_BOOT;
      cnt         <= '0;
      mask_q      <= DEFAULT_MASK;
      rem_q       <= '0;
      drive_q     <= 1'b0;
      fall_seen_q <= 1'b0;
      adc_cs_n    <= 1'b1;
      adc_wr_n    <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_convst  <= 1'b0;
      m_valid     <= 1'b0;
      m_data      <= '0;
      overrun     <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (!tdone)  cnt <= cnt + CNT_W'(1);

      adc_cs_n   <= !(nxt inside {ST_CFG_LO, ST_CFG_HI, ST_TURN, ST_RD_LO, ST_RD_HI});
      adc_wr_n   <= (nxt != ST_CFG_LO);
      adc_rd_n   <= (nxt != ST_RD_LO);
      adc_convst <= (nxt == ST_CNV);
      drive_q    <= (nxt inside {ST_CFG_LO, ST_CFG_HI});

      if (state == ST_BOOT)
        mask_q <= (cfg_mask == '0) ? DEFAULT_MASK : cfg_mask;

      if (state == ST_IDLE && start_req)
        rem_q <= mask_q;
      else if (state == ST_RD_LO && tdone)
        rem_q <= rem_q & ~pick_onehot;

      if (state == ST_RD_LO && tdone) begin
        m_valid <= 1'b1;
        m_data  <= {pick_ch, adc_data};
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end

      if (start_req && state != ST_IDLE) overrun <= 1'b1;

      if (state == ST_WAIT && nxt != ST_WAIT)
        fall_seen_q <= 1'b0;
      else if (eoc_fall && (state == ST_CNV || state == ST_WAIT))
        fall_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_sequencer_chk.sv
module adc_frame_sequencer_chk #(
  parameter int MW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          adc_cs_n,
  input logic          adc_wr_n,
  input logic          adc_rd_n,
  input logic          adc_convst,
  input logic          m_valid,
  input logic          m_ready,
  input logic [MW-1:0] m_data,
  input logic          overrun
);
  assert_wr_under_cs_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_wr_n) |-> !adc_cs_n);

  assert_read_under_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> !adc_cs_n);

  assert_convst_quiet_bus_R4: assert property (@(posedge clk) disable iff (rst)
    adc_convst |-> (adc_rd_n && adc_cs_n));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (adc_rd_n && m_valid && $stable(m_data)));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> adc_wr_n);
endmodule

bind adc_frame_sequencer adc_frame_sequencer_chk #(.MW(CW + DW)) u_chk (
  .clk(clk), .rst(rst), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
  .adc_rd_n(adc_rd_n), .adc_convst(adc_convst), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .overrun(overrun)
);

// File: tb/adc_frame_sequencer_tb.sv
`timescale 1ns/1ps
module adc_frame_sequencer_tb;
  localparam int RD_LO_W = 2;
  localparam int WR_LO_W = 2;
  localparam int EOC_DLY = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_frame = 1'b0;
  logic        timer_en = 1'b0;
  logic [15:0] timer_period = 16'd0;
  logic [7:0]  cfg_mask = 8'h00;
  logic        adc_cs_n, adc_wr_n, adc_rd_n, adc_convst;
  logic        adc_eoc_n = 1'b1;
  wire  [11:0] adc_data;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [14:0] m_data;
  logic        overrun;

  always #10 clk = ~clk;

  adc_frame_sequencer u_dut (
    .clk(clk), .rst(rst), .start_frame(start_frame), .timer_en(timer_en),
    .timer_period(timer_period), .cfg_mask(cfg_mask), .adc_cs_n(adc_cs_n),
    .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_convst(adc_convst),
    .adc_eoc_n(adc_eoc_n), .adc_data(adc_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .overrun(overrun)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] m);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [7:0] eff(input logic [7:0] m);
    return (m == 8'h00) ? 8'h1F : m;
  endfunction

  function automatic int nth_ch(input logic [7:0] m, input int n);
    int k = 0;
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        if (k == n) return i;
        k++;
      end
    return 0;
  endfunction

  function automatic int next_ch(input logic [7:0] m, input int cur);
    for (int i = cur + 1; i < 8; i++) if (m[i]) return i;
    return nth_ch(m, 0);
  endfunction

  function automatic logic [11:0] sample_val(input int id, input int ch);
    return 12'((id * 397 + ch * 1103 + 90) & 32'hFFF);
  endfunction

  // ---------------- converter model ----------------
  logic [7:0] lat_mask;
  logic [3:0] lat_hi;
  int  wr_cnt, conv_id, ptr, rd_falls, early, cfg_late, width_bad;
  int  eoc_cd, rd_run, wr_run, cyc, last_cyc, last_int;
  logic wr_p, rd_p, cv_p;

  assign adc_data = (!adc_rd_n && !adc_cs_n && !rst) ? sample_val(conv_id, ptr) : 12'hzzz;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      lat_mask = 8'h00; lat_hi = 4'h0; wr_cnt = 0; conv_id = 0; ptr = 0;
      rd_falls = 0; early = 0; cfg_late = 0; width_bad = 0; eoc_cd = 0;
      rd_run = 0; wr_run = 0; last_cyc = 0; last_int = 0;
      wr_p = 1'b1; rd_p = 1'b1; cv_p = 1'b0; adc_eoc_n = 1'b1;
    end else begin
      if (eoc_cd > 0) begin
        eoc_cd--;
        if (eoc_cd == 0) adc_eoc_n = 1'b0;
      end
      if (!adc_wr_n) wr_run++;
      if (wr_p == 1'b0 && adc_wr_n == 1'b1) begin
        if (wr_run != WR_LO_W) width_bad++;
        wr_run = 0;
        if (!adc_cs_n) begin
          lat_mask = adc_data[7:0];
          lat_hi   = adc_data[11:8];
          wr_cnt++;
          ptr = nth_ch(lat_mask, 0);
        end
      end
      if (!adc_rd_n) rd_run++;
      if (rd_p == 1'b1 && adc_rd_n == 1'b0) begin
        rd_falls++;
        if (adc_eoc_n) early++;
      end
      if (rd_p == 1'b0 && adc_rd_n == 1'b1) begin
        if (rd_run != RD_LO_W) width_bad++;
        rd_run = 0;
        ptr = next_ch(lat_mask, ptr);
      end
      if (cv_p == 1'b0 && adc_convst == 1'b1) begin
        if (wr_cnt == 0) cfg_late++;
        if (conv_id > 0) last_int = cyc - last_cyc;
        last_cyc = cyc;
        conv_id++;
        adc_eoc_n = 1'b1;
        eoc_cd = EOC_DLY;
      end
      wr_p = adc_wr_n; rd_p = adc_rd_n; cv_p = adc_convst;
    end
  end

  // ---------------- stream consumer ----------------
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int exp_frame, rx_in_frame, rx_total;
  bit stall_p;
  logic [14:0] data_p;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      exp_frame = 1; rx_in_frame = 0; rx_total = 0; stall_p = 1'b0;
      m_ready = 1'b0;
    end else begin
      if (stall_p) begin
        chk(adc_rd_n == 1'b1, "R7 read strobe held high during stall", int'(adc_rd_n), 1);
        chk(m_valid && m_data == data_p, "R7 output held during stall", int'(m_data), int'(data_p));
      end
      case (rdy_mode)
        0:       m_ready = 1'b1;
        1:       m_ready = lfsr[0];
        default: m_ready = ((cyc % 40) >= 30);
      endcase
      if (m_valid && m_ready) begin
        int ec;
        ec = nth_ch(eff(cfg_mask), rx_in_frame);
        chk(int'(m_data[14:12]) == ec, "R6 channel index order", int'(m_data[14:12]), ec);
        chk(m_data[11:0] == sample_val(exp_frame, ec), "R6 sample data",
            int'(m_data[11:0]), int'(sample_val(exp_frame, ec)));
        rx_in_frame++;
        rx_total++;
        if (rx_in_frame == popc(eff(cfg_mask))) begin
          rx_in_frame = 0;
          exp_frame++;
        end
      end
      stall_p = m_valid && !m_ready;
      data_p  = m_data;
    end
  end

  // ---------------- sequences ----------------
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n && !adc_convst && !m_valid && !overrun,
        "R1 reset state", {adc_cs_n, adc_wr_n, adc_rd_n, adc_convst, m_valid, overrun}, 6'b111000);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(!adc_convst && adc_rd_n && !m_valid && !overrun, "R1 idle after config",
        {adc_convst, adc_rd_n, m_valid, overrun}, 4'b0100);
  endtask

  task automatic pulse_start();
    start_frame = 1'b1;
    @(negedge clk);
    start_frame = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    int t = 0;
    while (rx_total < target && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(rx_total == target, "R6 frame delivered", rx_total, target);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // sweep every mask, including zero (default mask)
    for (int m = 0; m < 256; m++) begin
      int pc;
      cfg_mask = 8'(m);
      rdy_mode = m % 3;
      pc = popc(eff(8'(m)));
      do_reset();
      chk(wr_cnt == 1, "R2 single configuration write", wr_cnt, 1);
      chk(lat_mask == eff(8'(m)), (m == 0) ? "R3 default mask written" : "R2 mask on bus",
          int'(lat_mask), int'(eff(8'(m))));
      chk(lat_hi == 4'h0, "R2 upper bus bits zero", int'(lat_hi), 0);
      for (int f = 1; f <= 2; f++) begin
        pulse_start();
        wait_rx(f * pc);
        repeat (20) @(negedge clk);
        chk(rd_falls == f * pc, "R5 read pulses per frame", rd_falls, f * pc);
        chk(conv_id == f, "R4 one convert pulse per start", conv_id, f);
      end
      chk(early == 0, "R4 no read before end of conversion", early, 0);
      chk(cfg_late == 0, "R2 configuration before convert", cfg_late, 0);
      chk(width_bad == 0, "R10 strobe widths", width_bad, 0);
      chk(wr_cnt == 1, "R2 no repeat configuration", wr_cnt, 1);
      chk(!overrun, "R9 no overrun in normal use", int'(overrun), 0);
    end

    // overrun: start while busy is dropped and flagged
    cfg_mask = 8'hFF;
    rdy_mode = 0;
    do_reset();
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(overrun, "R9 overrun set by busy start", int'(overrun), 1);
    wait_rx(8);
    repeat (200) @(negedge clk);
    chk(conv_id == 1, "R9 busy start dropped", conv_id, 1);
    chk(rd_falls == 8, "R5 full mask eight reads", rd_falls, 8);
    pulse_start();
    wait_rx(16);
    repeat (20) @(negedge clk);
    chk(conv_id == 2 && overrun, "R9 overrun sticky across frames", conv_id, 2);

    // periodic timer
    cfg_mask = 8'h01;
    do_reset();
    timer_period = 16'd120;
    timer_en = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      int t = 0;
      while (conv_id < k && t < 400) begin
        @(negedge clk);
        t++;
      end
      if (k > 1) chk(last_int == 120, "R8 timer interval", last_int, 120);
    end
    chk(!overrun, "R8 timer no overrun when frames fit", int'(overrun), 0);
    timer_period = 16'd3;
    repeat (60) @(negedge clk);
    chk(overrun, "R9 short timer period overruns", int'(overrun), 1);
    timer_en = 1'b0;
    repeat (100) @(negedge clk);
    chk(early == 0 && width_bad == 0, "R10 timer run strobes", early + width_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule